// File: doc/BRIEF.md
# Page-granular secure memory zone filter

This block judges each transaction aimed at on-chip memories that are split into a protected lower part and an open upper part. Every zone has a fixed base and a fixed length in 4096-byte pages, both set at build time. A programmed page count marks where the protected part ends. Pages below that count, counted from the zone base, accept only secure traffic. Pages at or above it accept anyone. Two zones are instantiated by default: a small boot memory and a larger working RAM.

For each request strobe, the block registers one verdict. The verdict is a grant, a deny with an error flag, or a miss when the address falls in no zone. The page counts come from a register bank that sits outside this block. A per-zone freeze input makes the filter keep its held count until the next reset. Register access and the bus protocol stay outside the block.

Top module: `szf_filter`

## Requirements
- R1: Within a zone, an address whose byte offset from the zone base, shifted right by 12, is less than the held page count lies in the protected part. Any other address in the zone lies in the open part.
- R2: A non-secure request (`req_secure`=0) to the protected part is denied (`rsp_grant`=0, `rsp_error`=1). A non-secure request to the open part is granted (`rsp_grant`=1, `rsp_error`=0).
- R3: A secure request (`req_secure`=1) that hits a zone is always granted and never raises `rsp_error`.
- R4: A held count of 0 opens the whole zone. A held count equal to or above the zone's page length protects the whole zone, up to its last byte.
- R5: `req_write` (1 = write, 0 = read) has no effect on the verdict.
- R6: An address outside every zone's base-to-top range gives `rsp_miss`=1 with `rsp_grant`=0 and `rsp_error`=0. Exactly one of grant, error and miss is high in each response.
- R7: Zones have independent bases and counts. `rsp_zone` gives the index of the zone that was hit (0 = boot memory at 0x0000_0000, 32 pages; 1 = RAM at 0x1000_0000, 64 pages) and is 0 on a miss. `cfg_size` bits [9:0] hold zone 0's count and bits [19:10] hold zone 1's count.
- R8: The verdict for a request sampled at clock edge k appears after edge k and lasts one cycle. `rsp_valid` follows `req_valid`. With no request, all response outputs are low, so an error is flagged for its own transaction only.
- R9: Each zone copies its `cfg_size` field into a held count at every clock edge while unfrozen. A request sampled at the same edge as a new count is judged with the previous count.
- R10: When `cfg_lock[z]` is seen high at an edge, zone z keeps the count taken at that edge and ignores later `cfg_size` changes. This holds after `cfg_lock[z]` drops, until reset. Other zones are not affected.
- R11: Synchronous active-low reset clears all response outputs and all freezes, and sets every held count to all ones (whole zone protected). A request at the first edge after reset is therefore judged with the zone fully protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_addr | input | 32 | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure initiator, 0 = non-secure |
| cfg_size | input | 20 | Protected page count per zone, 10 bits each |
| cfg_lock | input | 2 | Freeze request per zone |
| rsp_valid | output | 1 | Verdict present |
| rsp_grant | output | 1 | Request allowed |
| rsp_error | output | 1 | Request denied, error response |
| rsp_miss | output | 1 | Address outside every zone |
| rsp_zone | output | 1 | Index of the zone that was hit |

## Verification
The hardest states to reach from the ports are those where the held count differs from the value currently on `cfg_size`. This happens in three cases: just after reset, at the edge where a new count arrives, and while a zone is frozen. The bench reaches the first case by presenting a non-secure request at the very edge where reset is released, with a zero count already applied. It reaches the second by changing the count and presenting a request in the same cycle. It reaches the third by pulsing the freeze for one cycle and then driving counts that would otherwise open the zone, with probes on both sides of the frozen boundary.

// File: rtl/szf_pkg.sv
// Package: shared constants and types for the secure zone filter.
// Assumes byte addressing and a page of 4096 bytes.
package szf_pkg;

    localparam int unsigned PAGE_SHIFT_4K = 12;

    // One registered verdict: exactly one field set for a valid request.
    typedef struct packed {
        logic grant;
        logic error;
        logic miss;
    } verdict_t;

endpackage

// File: rtl/szf_zone_cfg.sv
// Module: szf_zone_cfg
// Holds one zone's protected page count. The count follows the incoming
// field each cycle until a freeze is seen. From then on the count is held
// until reset. Assumes the register bank drives cfg_size and cfg_lock
// synchronously to clk.
module szf_zone_cfg #(
    parameter int unsigned SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_lock,
    output logic [SIZE_W-1:0] size_q,
    output logic              lock_q
);

    // Sticky freeze flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (cfg_lock) begin
            lock_q <= 1'b1;
        end
    end

    // Held count: resets to fully protected, tracks input while unfrozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '1;
        end else if (!lock_q) begin
            size_q <= cfg_size;
        end
    end

endmodule

// File: rtl/szf_zone_match.sv
// Module: szf_zone_match
// Combinational range check for one zone. It reports whether the address
// falls inside [BASE, BASE + PAGES pages) and whether it lies below the
// protected page boundary. Assumes BASE is page aligned and the zone does
// not wrap the address space.
module szf_zone_match #(
    parameter int unsigned              ADDR_W     = 32,
    parameter int unsigned              SIZE_W     = 10,
    parameter int unsigned              PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0]        BASE       = '0,
    parameter int unsigned              PAGES      = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              hit,
    output logic              guarded
);

    localparam logic [ADDR_W-1:0] PAGES_V = ADDR_W'(PAGES);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] page_idx;

    // Page index of the address relative to the zone base.
    always_comb begin
        offset   = addr - BASE;
        page_idx = offset >> PAGE_SHIFT;
    end

    // Zone membership and protected-part test on whole pages.
    always_comb begin
        hit     = (addr >= BASE) && (page_idx < PAGES_V);
        guarded = page_idx < ADDR_W'(size);
    end

endmodule

// File: rtl/szf_resp_reg.sv
// Module: szf_resp_reg
// Picks the hit zone (the lowest index wins if hits ever overlap), forms
// the verdict and registers it for one cycle per request. Assumes at most
// one zone is hit in a correctly configured system.
module szf_resp_reg
    import szf_pkg::*;
#(
    parameter int unsigned NUM_ZONES = 2,
    parameter int unsigned ZONE_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_secure,
    input  logic [NUM_ZONES-1:0] hit_vec,
    input  logic [NUM_ZONES-1:0] guard_vec,
    output logic                 rsp_valid,
    output logic                 rsp_grant,
    output logic                 rsp_error,
    output logic                 rsp_miss,
    output logic [ZONE_W-1:0]    rsp_zone
);

    logic              sel_hit;
    logic              sel_guard;
    logic [ZONE_W-1:0] sel_idx;
    verdict_t          next_v;
    verdict_t          held_v;

    // Priority select over zones, lowest index last so it wins.
    always_comb begin
        sel_hit   = 1'b0;
        sel_guard = 1'b0;
        sel_idx   = '0;
        for (int z = NUM_ZONES - 1; z >= 0; z--) begin
            if (hit_vec[z]) begin
                sel_hit   = 1'b1;
                sel_guard = guard_vec[z];
                sel_idx   = ZONE_W'(z);
            end
        end
    end

    // Verdict: deny non-secure inside the protected part, miss off-zone.
    always_comb begin
        next_v.error = req_valid && sel_hit && sel_guard && !req_secure;
        next_v.grant = req_valid && sel_hit && !(sel_guard && !req_secure);
        next_v.miss  = req_valid && !sel_hit;
    end

    // Response register, one cycle per request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            held_v    <= '0;
            rsp_zone  <= '0;
        end else begin
            rsp_valid <= req_valid;
            held_v    <= next_v;
            rsp_zone  <= (req_valid && sel_hit) ? sel_idx : '0;
        end
    end

    // Unpack the held verdict onto the outputs.
    always_comb begin
        rsp_grant = held_v.grant;
        rsp_error = held_v.error;
        rsp_miss  = held_v.miss;
    end

endmodule

// File: rtl/szf_filter.sv
// Module: szf_filter (top)
// Secure memory zone filter. Each zone has a build-time base and page
// length and a programmed protected page count. Non-secure requests below
// the boundary are denied, and addresses outside every zone are flagged as
// misses. Assumes zones are disjoint and page aligned. The read/write flag
// is accepted but does not take part in the decision.
module szf_filter #(
    parameter int unsigned                     ADDR_W     = 32,
    parameter int unsigned                     SIZE_W     = 10,
    parameter int unsigned                     NUM_ZONES  = 2,
    parameter logic [NUM_ZONES*ADDR_W-1:0]     ZONE_BASE  = {32'h1000_0000, 32'h0000_0000},
    parameter logic [NUM_ZONES*ADDR_W-1:0]     ZONE_PAGES = {32'd64, 32'd32},
    localparam int unsigned                    ZONE_W     = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    input  logic                        req_secure,
    input  logic [NUM_ZONES*SIZE_W-1:0] cfg_size,
    input  logic [NUM_ZONES-1:0]        cfg_lock,
    output logic                        rsp_valid,
    output logic                        rsp_grant,
    output logic                        rsp_error,
    output logic                        rsp_miss,
    output logic [ZONE_W-1:0]           rsp_zone
);

    logic [NUM_ZONES*SIZE_W-1:0] size_q;
    logic [NUM_ZONES-1:0]        lock_q;
    logic [NUM_ZONES-1:0]        hit_vec;
    logic [NUM_ZONES-1:0]        guard_vec;
    logic                        unused_write;

    // The access direction does not influence the verdict.
    assign unused_write = req_write;

    // One held count and one range check per zone.
    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        szf_zone_cfg #(
            .SIZE_W (SIZE_W)
        ) i_cfg (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_size (cfg_size[z*SIZE_W +: SIZE_W]),
            .cfg_lock (cfg_lock[z]),
            .size_q   (size_q[z*SIZE_W +: SIZE_W]),
            .lock_q   (lock_q[z])
        );

        szf_zone_match #(
            .ADDR_W     (ADDR_W),
            .SIZE_W     (SIZE_W),
            .PAGE_SHIFT (szf_pkg::PAGE_SHIFT_4K),
            .BASE       (ZONE_BASE[z*ADDR_W +: ADDR_W]),
            .PAGES      (ZONE_PAGES[z*ADDR_W +: ADDR_W])
        ) i_match (
            .addr    (req_addr),
            .size    (size_q[z*SIZE_W +: SIZE_W]),
            .hit     (hit_vec[z]),
            .guarded (guard_vec[z])
        );
    end

    szf_resp_reg #(
        .NUM_ZONES (NUM_ZONES),
        .ZONE_W    (ZONE_W)
    ) i_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_secure (req_secure),
        .hit_vec    (hit_vec),
        .guard_vec  (guard_vec),
        .rsp_valid  (rsp_valid),
        .rsp_grant  (rsp_grant),
        .rsp_error  (rsp_error),
        .rsp_miss   (rsp_miss),
        .rsp_zone   (rsp_zone)
    );

endmodule

// File: rtl/szf_filter_chk.sv
// Module: szf_filter_chk
// Property checker for szf_filter, attached through bind. It watches the
// request and response ports and the per-zone held counts and freezes.
module szf_filter_chk #(
    parameter int unsigned NUM_ZONES = 2,
    parameter int unsigned SIZE_W    = 10
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_secure,
    input logic                        rsp_valid,
    input logic                        rsp_grant,
    input logic                        rsp_error,
    input logic                        rsp_miss,
    input logic [NUM_ZONES-1:0]        hit_vec,
    input logic [NUM_ZONES-1:0]        lock_q,
    input logic [NUM_ZONES*SIZE_W-1:0] size_q
);

    AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_valid || rsp_grant || rsp_error || rsp_miss)); // R8

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_grant, rsp_error, rsp_miss}) == 1); // R6

    AST_SECURE_NOT_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_secure) |=> !rsp_error); // R3

    AST_ZONES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R7

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zchk
        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[z] |=> lock_q[z]); // R10

        AST_LOCK_HOLDS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[z] |=> $stable(size_q[z*SIZE_W +: SIZE_W])); // R10
    end

endmodule

bind szf_filter szf_filter_chk #(
    .NUM_ZONES (NUM_ZONES),
    .SIZE_W    (SIZE_W)
) i_szf_filter_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_secure (req_secure),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_error  (rsp_error),
    .rsp_miss   (rsp_miss),
    .hit_vec    (hit_vec),
    .lock_q     (lock_q),
    .size_q     (size_q)
);

// File: tb/test_szf_filter.sv
module test_szf_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [19:0] cfg_size = '0;
    logic [1:0]  cfg_lock = '0;
    logic        rsp_valid, rsp_grant, rsp_error, rsp_miss;
    logic [0:0]  rsp_zone;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    szf_filter i_szf_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_secure(req_secure), .cfg_size(cfg_size),
        .cfg_lock(cfg_lock), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_error(rsp_error), .rsp_miss(rsp_miss), .rsp_zone(rsp_zone)
    );

    typedef struct packed {
        logic [9:0]  s0;
        logic [9:0]  s1;
        logic [31:0] addr;
        logic        wr;
        logic        sec;
        logic        g;
        logic        e;
        logic        m;
        logic        z;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{10'd4,    10'd0,    32'h0000_3FFC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 last protected byte
        '{10'd4,    10'd0,    32'h0000_4000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 first open byte
        '{10'd4,    10'd0,    32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 secure write protected
        '{10'd0,    10'd0,    32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 zero count opens zone
        '{10'd1023, 10'd0,    32'h0001_FFFC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 max count
        '{10'd32,   10'd0,    32'h0001_FFFC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 count equals length
        '{10'd31,   10'd0,    32'h0001_F000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 last page open
        '{10'd31,   10'd0,    32'h0001_EFFC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 below boundary
        '{10'd0,    10'd16,   32'h1000_F000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 zone1 protected
        '{10'd0,    10'd16,   32'h1001_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 zone1 open
        '{10'd0,    10'd16,   32'h1000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 write denied alike
        '{10'd0,    10'd16,   32'h1001_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 write granted alike
        '{10'd0,    10'd16,   32'h0002_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 past zone0 top
        '{10'd0,    10'd16,   32'h0FFF_FFFC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 gap, secure
        '{10'd0,    10'd16,   32'h1004_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 past zone1 top
        '{10'd0,    10'd16,   32'h1003_FFFC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 zone1 last byte
        '{10'd1023, 10'd1023, 32'h1003_FFFC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 fully protected
        '{10'd1023, 10'd1023, 32'h1003_FFFC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 zone1 full
        '{10'd32,   10'd0,    32'h1000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}  // R7 independent counts
    };

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got {v,g,e,m,z}=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {rsp_valid, rsp_grant, rsp_error, rsp_miss, rsp_zone[0]};
    endfunction

    // At a negedge: drive request, sample its verdict one edge later.
    task automatic probe(input string tag, input logic [31:0] a, input logic w, input logic s,
                         input logic [4:0] exp);
        req_valid = 1'b1; req_addr = a; req_write = w; req_secure = s;
        @(negedge clk);
        check(tag, outs(), exp);
        req_valid = 1'b0;
    endtask

    task automatic set_sizes(input logic [9:0] s0, input logic [9:0] s1);
        cfg_size = {s1, s0};
        @(negedge clk);
    endtask

    initial begin
        // R11: outputs low while reset held, even with a request present
        req_valid = 1'b1; req_addr = 32'h0; req_secure = 1'b0;
        cfg_size = '0;
        repeat (3) @(negedge clk);
        check("R11 reset quiet", outs(), 5'b00000);
        // R11: first edge after reset uses fully protected held count
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset count protects", outs(), 5'b10100);
        req_valid = 1'b0;
        @(negedge clk);
        check("R8 idle after request", outs(), 5'b00000);

        // table walk
        for (int i = 0; i < NV; i++) begin
            set_sizes(VEC[i].s0, VEC[i].s1);
            probe($sformatf("table[%0d]", i), VEC[i].addr, VEC[i].wr, VEC[i].sec,
                  {1'b1, VEC[i].g, VEC[i].e, VEC[i].m, VEC[i].z});
        end

        // R8: back-to-back deny then grant, error only for the first
        set_sizes(10'd4, 10'd0);
        req_valid = 1'b1; req_addr = 32'h0000_1000; req_secure = 1'b0;
        @(negedge clk);
        check("R8 first deny", outs(), 5'b10100);
        req_addr = 32'h0000_5000;
        @(negedge clk);
        check("R8 second grant", outs(), 5'b11000);
        req_valid = 1'b0;
        @(negedge clk);
        check("R8 idle no error", outs(), 5'b00000);

        // R9: new count at the same edge as the request applies one edge late
        cfg_size = {10'd0, 10'd0};
        probe("R9 old count used", 32'h0, 1'b0, 1'b0, 5'b10100);
        probe("R9 new count used", 32'h0, 1'b0, 1'b0, 5'b11000);

        // R10: freeze zone0 at 8 pages, then try to open it
        cfg_size = {10'd0, 10'd8};
        cfg_lock = 2'b01;
        @(negedge clk);
        cfg_lock = 2'b00;
        set_sizes(10'd0, 10'd0);
        probe("R10 frozen deny", 32'h0000_7FFC, 1'b0, 1'b0, 5'b10100);
        probe("R10 frozen boundary", 32'h0000_8000, 1'b0, 1'b0, 5'b11000);
        probe("R10 other zone free", 32'h1000_0000, 1'b0, 1'b0, 5'b11001);
        set_sizes(10'd1023, 10'd1023);
        probe("R10 max ignored", 32'h0000_8000, 1'b0, 1'b0, 5'b11000);
        probe("R10 zone1 follows", 32'h1000_0000, 1'b0, 1'b0, 5'b10101);

        // R11: reset clears the freeze
        rst_n = 1'b0;
        cfg_size = {10'd0, 10'd0};
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        probe("R11 freeze cleared", 32'h0000_7FFC, 1'b0, 1'b0, 5'b11000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule